// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide register front end of an eight-line programmable interrupt controller. Software reaches it through two addresses. On address 0, a byte with bit 4 set begins an initialization sequence, and any other byte is an operation command. On address 1, a byte is either the next initialization word or a new interrupt mask. The block holds the mask, the in-service register, the priority rotation offset, the vector base and the mode flags. It also carries out the end-of-interrupt commands, the rotation commands, the acknowledge cycle and the destructive poll read.

The request latch and the priority resolver sit outside the block. The latch supplies its current request register. The resolver reports whether a line is pending and which line it is. The block exports its mask, in-service bits, rotation offset and flags so that the resolver can make that decision. Every bus access is a single-cycle strobe, and all state changes on the clock edge that ends the strobe.

Top module: `pic_cmd_seq`

## Requirements
- R1: After a synchronous reset, the following are all zero: the mask, the in-service register, the rotation offset, the nested, auto-EOI and special-mask flags, the read select and the poll flag. An address-0 read then returns the request input, and an address-1 read returns 0.
- R2: An address-0 write with bit 4 set does the following:
  - It clears the mask, the rotation offset, the special-mask flag and the read select.
  - It records bit 0 as "fourth word expected".
  - If bit 0 is 0, it also clears the nested and auto-EOI flags.
- R3: After initialization starts, the first address-1 write sets the vector base to the byte AND 0xF8. The second address-1 write ends the sequence unless a fourth word is expected. Address-1 writes inside the sequence leave the mask unchanged.
- R4: The fourth word, when it is expected, sets the nested flag from bit 4 and the auto-EOI flag from bit 1, and then ends the sequence.
- R5: An address-1 write outside initialization loads the mask. An address-1 read returns the mask.
- R6: An address-0 write with bit 3 = 1 and bit 4 = 0 does the following:
  - If bit 1 is set, it loads the read select from bit 0. Read select 1 makes address-0 reads return the in-service register, and read select 0 makes them return the request input.
  - If bit 6 is set, it loads the special-mask flag from bit 5.
  - If bit 2 is set, it sets poll.
- R7: Command code 1 clears the highest-priority in-service bit. The search takes lines in the order offset, offset+1, … (mod 8). If the in-service register is empty, the command changes nothing. The command code is bits 7:5 of an address-0 write with bits 4:3 = 00.
- R8: Command code 5 clears the same bit as code 1 and sets the offset to that line + 1 (mod 8). If the in-service register is empty, the command changes nothing.
- R9: Command code 3 clears the in-service bit named by bits 2:0. Command code 7 does the same and also sets the offset to that line + 1 (mod 8).
- R10: Command code 6 sets the offset to bits 2:0 + 1 (mod 8).
- R11: Command codes 0 and 4 set the rotate-on-auto-EOI flag to bit 7. With auto-EOI on, an acknowledge sets the offset to line + 1 only while that flag is set.
- R12: An acknowledge with a pending line puts base + line on the vector output. Without auto-EOI, it sets that line's in-service bit. With auto-EOI, it leaves the in-service register unchanged.
- R13: An acknowledge with nothing pending puts base + 7 on the vector output and leaves the in-service register unchanged.
- R14: A read while poll is set does the following:
  - It returns the pending line, or 7 if no line is pending.
  - It pulses the request-clear bit of that line.
  - It clears that line's in-service bit.
  - It clears poll, so the next read is a normal register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while rd_en is high |
| req_i | input | 8 | Request register from the external latch |
| pend_valid_i | input | 1 | Resolver has a pending line |
| pend_line_i | input | 3 | Pending line chosen by the resolver |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| vector_o | output | 8 | Vector returned during acknowledge |
| req_clr_o | output | 8 | One-cycle request clear toward the latch (poll) |
| mask_o | output | 8 | Interrupt mask |
| isr_o | output | 8 | In-service register |
| offset_o | output | 3 | Priority rotation offset |
| nested_o | output | 1 | Special fully nested mode flag |
| aeoi_o | output | 1 | Auto-EOI flag |
| smask_o | output | 1 | Special-mask flag |

## Verification
The non-specific and rotating end-of-interrupt commands are swept over all eight rotation offsets, with several in-service patterns at each offset: full, sparse, adjacent and two-bit. This shows whether the search starts at the offset and wraps, rather than always favouring line 0. Acknowledge and specific clear are swept over every line, which catches a wrong bit index or a wrong vector sum. Initialization is run both with and without the fourth word. A mask write that follows each sequence shows whether the step count is right. Poll is tried with and without a pending line, which separates the spurious value 7 from a real line and confirms that the poll flag is dropped after one read.

// File: rtl/pic_seq_pkg.sv
// Package: shared encodings of the command sequencer.
// Assumes eight interrupt lines and a byte-wide register interface.
package pic_seq_pkg;

    // Steps of the initialization sequence
    typedef enum logic [1:0] {
        INIT_IDLE = 2'd0,
        INIT_BASE = 2'd1,
        INIT_CASC = 2'd2,
        INIT_MODE = 2'd3
    } init_state_e;

    // Operation command codes (bits 7:5 of an address-0 command byte)
    typedef enum logic [2:0] {
        OP_ROT_OFF  = 3'd0,
        OP_EOI_NS   = 3'd1,
        OP_NOP      = 3'd2,
        OP_EOI_SP   = 3'd3,
        OP_ROT_ON   = 3'd4,
        OP_EOI_NSR  = 3'd5,
        OP_SET_PRIO = 3'd6,
        OP_EOI_SPR  = 3'd7
    } op_code_e;

endpackage

// File: rtl/pic_prio_pick.sv
// Module: rotating priority picker.
// Finds the first set bit of 'bits' when lines are scanned starting at
// 'offset' and wrapping; that line has the highest priority.
// Assumes LINES is a power of two, so offset arithmetic wraps naturally.
module pic_prio_pick #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic [LINES-1:0] bits,
    input  logic [LW-1:0]    offset,
    output logic             found,
    output logic [LW-1:0]    line
);

    // Scan from the lowest priority to the highest, so the last hit wins
    always_comb begin
        logic [LW-1:0] idx;
        found = 1'b0;
        line  = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            idx = offset + LW'(i);
            if (bits[idx]) begin
                found = 1'b1;
                line  = idx;
            end
        end
    end

endmodule

// File: rtl/pic_init_seq.sv
// Module: initialization sequencer.
// Holds the sequence state and the fourth-word-expected flag, the vector
// base, the nested and auto-EOI flags, and the interrupt mask.
// Assumes 'start' and 'data_wr' come from one single-cycle bus write and
// are never high together.
module pic_init_seq
    import pic_seq_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DW    = 8,
    localparam logic [DW-1:0] BASE_KEEP = ~DW'(LINES - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             data_wr,
    input  logic [DW-1:0]    wdata,
    output logic [LINES-1:0] mask_o,
    output logic [DW-1:0]    base_o,
    output logic             nested_o,
    output logic             aeoi_o
);

    init_state_e state;
    logic        need4;

    // Advance through the initialization steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= INIT_IDLE;
            need4 <= 1'b0;
        end else if (start) begin
            state <= INIT_BASE;
            need4 <= wdata[0];
        end else if (data_wr) begin
            case (state)
                INIT_BASE: state <= INIT_CASC;
                INIT_CASC: state <= need4 ? INIT_MODE : INIT_IDLE;
                INIT_MODE: state <= INIT_IDLE;
                default:   state <= INIT_IDLE;
            endcase
        end
    end

    // Capture the base word and the mode word; clear the modes when no fourth word follows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o   <= '0;
            nested_o <= 1'b0;
            aeoi_o   <= 1'b0;
        end else if (start) begin
            if (!wdata[0]) begin
                nested_o <= 1'b0;
                aeoi_o   <= 1'b0;
            end
        end else if (data_wr) begin
            if (state == INIT_BASE) begin
                base_o <= wdata & BASE_KEEP;
            end
            if (state == INIT_MODE) begin
                nested_o <= wdata[4];
                aeoi_o   <= wdata[1];
            end
        end
    end

    // Mask register: cleared on start, loaded by data writes outside the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (start) begin
            mask_o <= '0;
        end else if (data_wr && state == INIT_IDLE) begin
            mask_o <= wdata[LINES-1:0];
        end
    end

    // R2
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mask_o == '0 && state == INIT_BASE));

    // R3
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == INIT_BASE && data_wr && !start)
            |=> (state == INIT_CASC && base_o[$clog2(LINES)-1:0] == '0));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == INIT_IDLE && data_wr && !start)
            |=> (mask_o == $past(wdata[LINES-1:0])));

endmodule

// File: rtl/pic_isr_unit.sv
// Module: in-service register and priority rotation.
// Carries out the end-of-interrupt and rotation commands, the acknowledge
// cycle and the in-service clear of a poll read.
// Assumes at most one of op_wr, ack_take and poll_take per cycle; start is
// a write and never coincides with op_wr.
module pic_isr_unit
    import pic_seq_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_wr,
    input  logic [2:0]       op_code,
    input  logic [LW-1:0]    op_arg,
    input  logic             op_rot_bit,
    input  logic             ack_take,
    input  logic             poll_take,
    input  logic [LW-1:0]    pend_line,
    input  logic             aeoi,
    output logic [LINES-1:0] isr_o,
    output logic [LW-1:0]    offset_o
);

    logic             rot_aeoi;
    logic             top_found;
    logic [LW-1:0]    top_line;
    logic [LINES-1:0] isr_n;
    logic [LW-1:0]    off_n;
    logic             rot_n;

    pic_prio_pick #(.LINES(LINES)) u_top (
        .bits   (isr_o),
        .offset (offset_o),
        .found  (top_found),
        .line   (top_line)
    );

    // Work out the next in-service, offset and rotate-on-auto-EOI values
    always_comb begin
        isr_n = isr_o;
        off_n = offset_o;
        rot_n = rot_aeoi;
        if (start) begin
            off_n = '0;
        end else if (op_wr) begin
            case (op_code_e'(op_code))
                OP_ROT_OFF, OP_ROT_ON: rot_n = op_rot_bit;
                OP_EOI_NS: begin
                    if (top_found) isr_n[top_line] = 1'b0;
                end
                OP_EOI_NSR: begin
                    if (top_found) begin
                        isr_n[top_line] = 1'b0;
                        off_n = top_line + LW'(1);
                    end
                end
                OP_EOI_SP: isr_n[op_arg] = 1'b0;
                OP_SET_PRIO: off_n = op_arg + LW'(1);
                OP_EOI_SPR: begin
                    isr_n[op_arg] = 1'b0;
                    off_n = op_arg + LW'(1);
                end
                default: ;
            endcase
        end else if (ack_take) begin
            if (aeoi) begin
                if (rot_aeoi) off_n = pend_line + LW'(1);
            end else begin
                isr_n[pend_line] = 1'b1;
            end
        end else if (poll_take) begin
            isr_n[pend_line] = 1'b0;
        end
    end

    // Register the in-service state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_o    <= '0;
            offset_o <= '0;
            rot_aeoi <= 1'b0;
        end else begin
            isr_o    <= isr_n;
            offset_o <= off_n;
            rot_aeoi <= rot_n;
        end
    end

    // R12
    ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !aeoi && !op_wr && !start) |=> isr_o[$past(pend_line)]);

    // R7
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_code == 3'd1 && isr_o == '0) |=> (isr_o == '0));

    // R10
    prio_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_code == 3'd6) |=> (offset_o == LW'($past(op_arg) + LW'(1))));

endmodule

// File: rtl/pic_cmd_seq.sv
// Module: top of the interrupt controller command sequencer.
// Decodes the two-address byte interface into initialization, operation
// and mask writes; holds read select, special mask and poll; forms read
// data, the acknowledge vector and the poll request clear.
// Assumes wr_en, rd_en and ack_i are mutually exclusive single-cycle strobes,
// and that the external resolver keeps pend_valid_i/pend_line_i current.
module pic_cmd_seq
    import pic_seq_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DW    = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [LINES-1:0] req_i,
    input  logic             pend_valid_i,
    input  logic [LW-1:0]    pend_line_i,
    input  logic             ack_i,
    output logic [DW-1:0]    vector_o,
    output logic [LINES-1:0] req_clr_o,
    output logic [LINES-1:0] mask_o,
    output logic [LINES-1:0] isr_o,
    output logic [LW-1:0]    offset_o,
    output logic             nested_o,
    output logic             aeoi_o,
    output logic             smask_o
);

    localparam logic [LW-1:0] SPURIOUS = LW'(LINES - 1);

    logic          cmd_wr;
    logic          init_wr;
    logic          sel_wr;
    logic          op_wr;
    logic          data_wr;
    logic          read_sel;
    logic          poll_q;
    logic          poll_take;
    logic          ack_take;
    logic [DW-1:0] base;

    // Split a bus write into its command classes
    always_comb begin
        cmd_wr  = wr_en && !addr;
        init_wr = cmd_wr && wdata[4];
        sel_wr  = cmd_wr && !wdata[4] && wdata[3];
        op_wr   = cmd_wr && !wdata[4] && !wdata[3];
        data_wr = wr_en && addr;
    end

    // Strobes that take the pending line from the resolver
    always_comb begin
        ack_take  = ack_i && pend_valid_i;
        poll_take = rd_en && poll_q && pend_valid_i;
    end

    pic_init_seq #(.LINES(LINES), .DW(DW)) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (init_wr),
        .data_wr  (data_wr),
        .wdata    (wdata),
        .mask_o   (mask_o),
        .base_o   (base),
        .nested_o (nested_o),
        .aeoi_o   (aeoi_o)
    );

    pic_isr_unit #(.LINES(LINES)) u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (init_wr),
        .op_wr      (op_wr),
        .op_code    (wdata[7:5]),
        .op_arg     (wdata[LW-1:0]),
        .op_rot_bit (wdata[7]),
        .ack_take   (ack_take),
        .poll_take  (poll_take),
        .pend_line  (pend_line_i),
        .aeoi       (aeoi_o),
        .isr_o      (isr_o),
        .offset_o   (offset_o)
    );

    // Read select, special mask and poll flags from the select command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_sel <= 1'b0;
            smask_o  <= 1'b0;
            poll_q   <= 1'b0;
        end else if (init_wr) begin
            read_sel <= 1'b0;
            smask_o  <= 1'b0;
        end else if (sel_wr) begin
            if (wdata[2]) poll_q   <= 1'b1;
            if (wdata[1]) read_sel <= wdata[0];
            if (wdata[6]) smask_o  <= wdata[5];
        end else if (rd_en && poll_q) begin
            poll_q <= 1'b0;
        end
    end

    // Read data: poll result, or the register chosen by address and read select
    always_comb begin
        if (poll_q) begin
            rdata = DW'(pend_valid_i ? pend_line_i : SPURIOUS);
        end else if (addr) begin
            rdata = DW'(mask_o);
        end else if (read_sel) begin
            rdata = DW'(isr_o);
        end else begin
            rdata = DW'(req_i);
        end
    end

    // Acknowledge vector: base plus the pending line or the spurious line
    always_comb begin
        vector_o = '0;
        if (ack_i) begin
            vector_o = base | DW'(pend_valid_i ? pend_line_i : SPURIOUS);
        end
    end

    // Request clear pulse for the line taken by a poll read
    always_comb begin
        req_clr_o = '0;
        if (poll_take) req_clr_o[pend_line_i] = 1'b1;
    end

    // Interface assumption: one strobe per cycle
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_en, ack_i}));

    // R13
    spur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !pend_valid_i) |=> $stable(isr_o));

    // R14
    poll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_q) |=> !poll_q);

    // R6
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && wdata[6]) |=> (smask_o == $past(wdata[5])));

endmodule

// File: tb/pic_cmd_seq_bench.sv
module pic_cmd_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] req_i = 8'hA5;
    logic       pend_valid_i = 1'b0;
    logic [2:0] pend_line_i = '0;
    logic       ack_i = 1'b0;
    logic [7:0] vector_o;
    logic [7:0] req_clr_o;
    logic [7:0] mask_o;
    logic [7:0] isr_o;
    logic [2:0] offset_o;
    logic       nested_o;
    logic       aeoi_o;
    logic       smask_o;

    int total = 0;
    int fails = 0;
    logic [7:0] rv;
    logic [7:0] clr_seen;
    logic [7:0] m_isr;
    logic [2:0] m_off;

    always #4 clk = ~clk;

    pic_cmd_seq u_pic_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_i(req_i), .pend_valid_i(pend_valid_i),
        .pend_line_i(pend_line_i), .ack_i(ack_i), .vector_o(vector_o),
        .req_clr_o(req_clr_o), .mask_o(mask_o), .isr_o(isr_o), .offset_o(offset_o),
        .nested_o(nested_o), .aeoi_o(aeoi_o), .smask_o(smask_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 rv = rdata; clr_seen = req_clr_o;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ack(input logic v, input logic [2:0] line);
        @(negedge clk); pend_valid_i = v; pend_line_i = line; ack_i = 1'b1;
        #1 rv = vector_o;
        @(negedge clk); ack_i = 1'b0; pend_valid_i = 1'b0;
    endtask

    // Bench-side highest-priority search from the offset
    function automatic logic [3:0] top_of(input logic [7:0] s, input logic [2:0] off);
        for (int i = 0; i < 8; i++) begin
            logic [2:0] k;
            k = off + 3'(i);
            if (s[k]) return {1'b1, k};
        end
        return 4'd0;
    endfunction

    initial begin
        #(8 * 200000);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [3:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mask", mask_o, 0); check("R1 isr", isr_o, 0); check("R1 off", offset_o, 0);
        check("R1 flags", {nested_o, aeoi_o, smask_o}, 0);
        rd(1'b0); check("R1 rd0 request", rv, 8'hA5);
        rd(1'b1); check("R1 rd1 mask", rv, 0);

        // R5 mask load and read
        wr(1'b1, 8'h3C); check("R5 mask", mask_o, 8'h3C);
        rd(1'b1); check("R5 mask read", rv, 8'h3C);

        // R2/R3/R4 four-word init
        wr(1'b0, 8'h11); check("R2 mask cleared", mask_o, 0);
        wr(1'b1, 8'h4F); check("R3 mask held", mask_o, 0);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h12); check("R3 mask held 4w", mask_o, 0);
        check("R4 nested", nested_o, 1); check("R4 aeoi", aeoi_o, 1);
        ack(1'b0, 3'd0); check("R13 spurious vector", rv, 8'h4F);
        check("R13 isr unchanged", isr_o, 0);

        // R2/R3 three-word init clears modes
        wr(1'b0, 8'h10); check("R2 nested clr", nested_o, 0); check("R2 aeoi clr", aeoi_o, 0);
        wr(1'b1, 8'h23); wr(1'b1, 8'h00);
        wr(1'b1, 8'h81); check("R3 mask after 3w", mask_o, 8'h81);

        // R12 acknowledge sweep
        m_isr = 0;
        for (int l = 0; l < 8; l++) begin
            ack(1'b1, 3'(l));
            m_isr[l] = 1'b1;
            check("R12 vector", rv, 8'h20 + 8'(l));
            check("R12 isr set", isr_o, m_isr);
        end
        // R9 specific EOI sweep
        for (int l = 7; l >= 0; l--) begin
            wr(1'b0, 8'h60 | 8'(l));
            m_isr[l] = 1'b0;
            check("R9 specific clear", isr_o, m_isr);
        end

        // R7/R10 non-specific EOI across offsets and patterns
        for (int off = 0; off < 8; off++) begin
            wr(1'b0, 8'hC0 | 8'((off + 7) % 8));
            m_off = 3'(off);
            check("R10 offset", offset_o, m_off);
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pat;
                pat = (p == 0) ? 8'hFF : (p == 1) ? 8'h81 : (p == 2) ? 8'h5A : 8'h18;
                for (int l = 0; l < 8; l++) if (pat[l]) ack(1'b1, 3'(l));
                m_isr = pat;
                while (m_isr != 0) begin
                    t = top_of(m_isr, m_off);
                    m_isr[t[2:0]] = 1'b0;
                    wr(1'b0, 8'h20);
                    check("R7 eoi ns", isr_o, m_isr);
                end
            end
        end
        wr(1'b0, 8'h20); check("R7 empty no effect", isr_o, 0);

        // R8 rotating EOI
        wr(1'b0, 8'hC7); ack(1'b1, 3'd2); ack(1'b1, 3'd4);
        wr(1'b0, 8'hA0); check("R8 isr", isr_o, 8'h10); check("R8 off", offset_o, 3);
        wr(1'b0, 8'hA0); check("R8 isr2", isr_o, 0); check("R8 off2", offset_o, 5);
        wr(1'b0, 8'hA0); check("R8 empty off", offset_o, 5);

        // R9 specific rotate wraps
        ack(1'b1, 3'd7); wr(1'b0, 8'hE7);
        check("R9 spr isr", isr_o, 0); check("R9 spr off", offset_o, 0);

        // R11 rotate on auto-EOI
        wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
        wr(1'b0, 8'h80);
        ack(1'b1, 3'd5); check("R12 aeoi vector", rv, 8'h85);
        check("R12 aeoi isr", isr_o, 0); check("R11 rot off", offset_o, 6);
        wr(1'b0, 8'h00);
        ack(1'b1, 3'd2); check("R11 no rot", offset_o, 6);

        // R6 select command
        wr(1'b0, 8'h10); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
        ack(1'b1, 3'd3); ack(1'b1, 3'd6);
        wr(1'b0, 8'h0B); rd(1'b0); check("R6 read isr", rv, 8'h48);
        wr(1'b0, 8'h08); rd(1'b0); check("R6 sel kept", rv, 8'h48);
        wr(1'b0, 8'h68); check("R6 smask set", smask_o, 1);
        wr(1'b0, 8'h48); check("R6 smask clr", smask_o, 0);
        wr(1'b0, 8'h0A); rd(1'b0); check("R6 read request", rv, 8'hA5);

        // R14 poll
        wr(1'b0, 8'h0C);
        pend_valid_i = 1'b1; pend_line_i = 3'd3;
        rd(1'b0); check("R14 poll line", rv, 3); check("R14 req clr", clr_seen, 8'h08);
        pend_valid_i = 1'b0;
        check("R14 isr clr", isr_o, 8'h40);
        rd(1'b0); check("R14 poll cleared", rv, 8'hA5);
        wr(1'b0, 8'h0C);
        rd(1'b0); check("R14 poll none", rv, 7); check("R14 no clr", clr_seen, 0);
        check("R14 isr kept", isr_o, 8'h40);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule